// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block collects interrupt sources grouped by priority level. Each level has a vector of source bits that can be set or cleared one at a time, and a one-bit-per-level status word records which levels still hold at least one pending source. A single command wipes every vector and the status word at once.

Each cycle the block merges the external level status with a word of software interrupt requests. It picks the highest active level and builds a summary mask of every contributing bit. External levels sit above software levels. When that level is nonzero, above the current priority level, and the instruction address is word aligned, the block stages the level and mask and raises a request. The core then acknowledges the request, and the staged level and mask move onto the registered interrupt ID and summary outputs.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: A post with a level in 1..31 and an index in 0..31 sets that source bit and the level's bit of `lvl_status` (bit n = level n), visible the cycle after the post.
- R2: A clear removes the addressed source bit. The level's `lvl_status` bit drops only when no source bit of that level is left.
- R3: `clr_all` zeroes every source vector and `lvl_status` in one cycle, and wins over a post in the same cycle.
- R4: `irq_pending` is high one cycle after `lvl_status` is nonzero while `pc[1:0]` is 00, and low otherwise.
- R5: Each set bit i of `sw_req` with 1 <= i <= 15 gives candidate level i and sets summary bit i. Bit 0 and bits 16..31 of `sw_req` are ignored.
- R6: Each set `lvl_status` bit i with 16 <= i <= 31 gives candidate level i and sets summary bit i. The highest active bit wins, so any external level outranks every software level.
- R7: A request is staged only when the winning level is nonzero, strictly greater than `cur_ipl`, and `pc[1:0]` is 00.
- R8: `irq_req` rises the cycle after the request condition holds. An `ack` while `irq_req` is high puts the staged level on `int_id` and the staged mask on `int_sum` in the next cycle, and drops `irq_req` for that cycle.
- R9: An `ack` while `irq_req` is low leaves `int_id` and `int_sum` unchanged.
- R10: A post or clear with level 0, level above 31 or index above 31 changes no state, and it raises `cmd_err` for exactly the next cycle.
- R11: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_vld | input | 1 | Post command strobe |
| post_level | input | 6 | Level addressed by the post |
| post_index | input | 6 | Source index addressed by the post |
| clr_vld | input | 1 | Clear command strobe |
| clr_level | input | 6 | Level addressed by the clear |
| clr_index | input | 6 | Source index addressed by the clear |
| clr_all | input | 1 | Wipe all pending state |
| pc | input | 32 | Current instruction address |
| sw_req | input | 32 | Software interrupt request word |
| cur_ipl | input | 5 | Current priority level |
| ack | input | 1 | Acknowledge of the staged request |
| lvl_status | output | 32 | Per-level pending status |
| irq_pending | output | 1 | Any status bit set and address aligned |
| irq_req | output | 1 | Staged interrupt request |
| int_id | output | 5 | Committed interrupt level |
| int_sum | output | 32 | Committed summary mask |
| cmd_err | output | 1 | Out-of-range command pulse |

## Verification
The assertions assume that command fields are meaningful only while their strobe is high. They also assume that `ack` is a single-cycle strobe, and that `pc`, `sw_req` and `cur_ipl` stay constant within each cycle. The stimulus changes every input only at falling clock edges. It pulses each strobe for exactly one cycle, and it holds `pc`, `sw_req` and `cur_ipl` for at least one full cycle before any acknowledge, so the staged value reflects a settled candidate.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

  localparam int ALIGN_BITS = 2;

  // Checks that a (level, index) pair names a stored source; level 0 is reserved.
  function automatic logic addr_ok(input int lvl, input int idx,
                                   input int n_lvl, input int n_src);
    return (lvl >= 1) && (lvl < n_lvl) && (idx >= 0) && (idx < n_src);
  endfunction

endpackage

// File: rtl/lvl_irq_store.sv
module lvl_irq_store #(
  parameter int NUM_LEVELS = 32,
  parameter int SRC_BITS   = 32,
  parameter int AW         = 6,
  parameter int IW         = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  post_vld,
  input  logic [AW-1:0]         post_level,
  input  logic [IW-1:0]         post_index,
  input  logic                  clr_vld,
  input  logic [AW-1:0]         clr_level,
  input  logic [IW-1:0]         clr_index,
  input  logic                  clr_all,
  output logic [NUM_LEVELS-1:0] status,
  output logic                  err_q
);
  localparam int SW = $clog2(SRC_BITS);

  logic post_ok, clr_ok;
  logic [SRC_BITS-1:0] post_hot, clr_hot;

  assign post_ok  = post_vld && lvl_irq_pkg::addr_ok(int'(post_level), int'(post_index),
                                                     NUM_LEVELS, SRC_BITS);
  assign clr_ok   = clr_vld && lvl_irq_pkg::addr_ok(int'(clr_level), int'(clr_index),
                                                    NUM_LEVELS, SRC_BITS);
  assign post_hot = {{(SRC_BITS-1){1'b0}}, 1'b1} << post_index[SW-1:0];
  assign clr_hot  = {{(SRC_BITS-1){1'b0}}, 1'b1} << clr_index[SW-1:0];

  for (genvar L = 0; L < NUM_LEVELS; L++) begin : g_lvl
    logic [SRC_BITS-1:0] vec_q, vec_d;
    logic                stat_q;
    logic                hit_post, hit_clr;

    assign hit_post = post_ok && (post_level == AW'(L));
    assign hit_clr  = clr_ok  && (clr_level  == AW'(L));

    always_comb begin
      vec_d = vec_q;
      if (hit_clr)  vec_d = vec_d & ~clr_hot;
      if (hit_post) vec_d = vec_d | post_hot;
    end

    always_ff @(posedge clk) begin
      if (rst || clr_all) begin
        vec_q  <= '0;
        stat_q <= 1'b0;
      end else begin
        vec_q <= vec_d;
        if (hit_post)
          stat_q <= 1'b1;
        else if (hit_clr && (vec_d == '0))
          stat_q <= 1'b0;
      end
    end

    assign status[L] = stat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= (post_vld && !post_ok) || (clr_vld && !clr_ok);
  end

endmodule

// File: rtl/lvl_irq_prio.sv
module lvl_irq_prio #(
  parameter int NUM_LEVELS = 32,
  parameter int SW_MIN     = 1,
  parameter int SW_MAX     = 16,
  parameter int EXT_MIN    = 16,
  parameter int LW         = 5
) (
  input  logic [NUM_LEVELS-1:0] status,
  input  logic [NUM_LEVELS-1:0] sw_req,
  output logic [LW-1:0]         cand_lvl,
  output logic [NUM_LEVELS-1:0] cand_sum
);
  // Software range first, external range after it: the later match overrides.
  always_comb begin
    cand_lvl = '0;
    cand_sum = '0;
    for (int i = SW_MIN; i < SW_MAX; i++) begin
      if (sw_req[i]) begin
        cand_lvl    = LW'(i - SW_MIN + 1);
        cand_sum[i] = 1'b1;
      end
    end
    for (int i = EXT_MIN; i < NUM_LEVELS; i++) begin
      if (status[i]) begin
        cand_lvl    = LW'(i);
        cand_sum[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/lvl_irq_stage.sv
module lvl_irq_stage #(
  parameter int NUM_LEVELS = 32,
  parameter int LW         = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  take,
  input  logic [LW-1:0]         cand_lvl,
  input  logic [NUM_LEVELS-1:0] cand_sum,
  input  logic                  ack,
  output logic                  req_q,
  output logic [LW-1:0]         id_q,
  output logic [NUM_LEVELS-1:0] sum_q
);
  logic [LW-1:0]         stg_lvl;
  logic [NUM_LEVELS-1:0] stg_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b0;
      stg_lvl <= '0;
      stg_sum <= '0;
      id_q    <= '0;
      sum_q   <= '0;
    end else if (ack && req_q) begin
      id_q  <= stg_lvl;
      sum_q <= stg_sum;
      req_q <= 1'b0;
    end else begin
      req_q <= take;
      if (take) begin
        stg_lvl <= cand_lvl;
        stg_sum <= cand_sum;
      end
    end
  end

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
  parameter int NUM_LEVELS = 32,
  parameter int SRC_BITS   = 32,
  parameter int SW_MIN     = 1,
  parameter int SW_MAX     = 16,
  parameter int EXT_MIN    = 16,
  parameter int PC_W       = 32,
  localparam int LW        = $clog2(NUM_LEVELS),
  localparam int AW        = LW + 1,
  localparam int IW        = $clog2(SRC_BITS) + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  post_vld,
  input  logic [AW-1:0]         post_level,
  input  logic [IW-1:0]         post_index,
  input  logic                  clr_vld,
  input  logic [AW-1:0]         clr_level,
  input  logic [IW-1:0]         clr_index,
  input  logic                  clr_all,
  input  logic [PC_W-1:0]       pc,
  input  logic [NUM_LEVELS-1:0] sw_req,
  input  logic [LW-1:0]         cur_ipl,
  input  logic                  ack,
  output logic [NUM_LEVELS-1:0] lvl_status,
  output logic                  irq_pending,
  output logic                  irq_req,
  output logic [LW-1:0]         int_id,
  output logic [NUM_LEVELS-1:0] int_sum,
  output logic                  cmd_err
);
  logic                  aligned, take;
  logic [LW-1:0]         cand_lvl;
  logic [NUM_LEVELS-1:0] cand_sum;

  assign aligned = (pc[lvl_irq_pkg::ALIGN_BITS-1:0] == '0);

  lvl_irq_store #(.NUM_LEVELS(NUM_LEVELS), .SRC_BITS(SRC_BITS), .AW(AW), .IW(IW)) u_store (
    .clk(clk), .rst(rst),
    .post_vld(post_vld), .post_level(post_level), .post_index(post_index),
    .clr_vld(clr_vld), .clr_level(clr_level), .clr_index(clr_index),
    .clr_all(clr_all), .status(lvl_status), .err_q(cmd_err)
  );

  lvl_irq_prio #(.NUM_LEVELS(NUM_LEVELS), .SW_MIN(SW_MIN), .SW_MAX(SW_MAX),
                 .EXT_MIN(EXT_MIN), .LW(LW)) u_prio (
    .status(lvl_status), .sw_req(sw_req), .cand_lvl(cand_lvl), .cand_sum(cand_sum)
  );

  assign take = aligned && (cand_lvl != '0) && (cand_lvl > cur_ipl);

  lvl_irq_stage #(.NUM_LEVELS(NUM_LEVELS), .LW(LW)) u_stage (
    .clk(clk), .rst(rst), .take(take), .cand_lvl(cand_lvl), .cand_sum(cand_sum),
    .ack(ack), .req_q(irq_req), .id_q(int_id), .sum_q(int_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_pending <= 1'b0;
    else     irq_pending <= (|lvl_status) && aligned;
  end

endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
module lvl_irq_ctrl_chk #(
  parameter int NUM_LEVELS = 32,
  parameter int SRC_BITS   = 32,
  parameter int PC_W       = 32,
  localparam int LW        = $clog2(NUM_LEVELS),
  localparam int AW        = LW + 1,
  localparam int IW        = $clog2(SRC_BITS) + 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  post_vld,
  input logic [AW-1:0]         post_level,
  input logic [IW-1:0]         post_index,
  input logic                  clr_vld,
  input logic                  clr_all,
  input logic [PC_W-1:0]       pc,
  input logic                  ack,
  input logic [NUM_LEVELS-1:0] lvl_status,
  input logic                  irq_pending,
  input logic                  irq_req,
  input logic [LW-1:0]         int_id,
  input logic [NUM_LEVELS-1:0] int_sum,
  input logic                  cmd_err
);
  logic good_post;
  assign good_post = post_vld && (post_level != '0) && (int'(post_level) < NUM_LEVELS)
                     && (int'(post_index) < SRC_BITS);

  a_r1_post_sets: assert property (@(posedge clk) disable iff (rst)
    good_post && !clr_all |=> lvl_status[$past(post_level[LW-1:0])]);

  a_r3_clear_all_wins: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> lvl_status == '0);

  a_r4_pending_aligned: assert property (@(posedge clk) disable iff (rst)
    irq_pending |-> $past(pc[1:0]) == 2'b00);

  a_r8_ack_drops_req: assert property (@(posedge clk) disable iff (rst)
    ack && irq_req |=> !irq_req);

  a_r8_commit_nonzero: assert property (@(posedge clk) disable iff (rst)
    ack && irq_req |=> int_id != '0 && int_sum != '0);

  a_r9_idle_ack_stable: assert property (@(posedge clk) disable iff (rst)
    ack && !irq_req |=> $stable(int_id) && $stable(int_sum));

  a_r10_err_cause: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> $past(post_vld || clr_vld));

endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(.NUM_LEVELS(NUM_LEVELS), .SRC_BITS(SRC_BITS), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst(rst), .post_vld(post_vld), .post_level(post_level),
  .post_index(post_index), .clr_vld(clr_vld), .clr_all(clr_all), .pc(pc), .ack(ack),
  .lvl_status(lvl_status), .irq_pending(irq_pending), .irq_req(irq_req),
  .int_id(int_id), .int_sum(int_sum), .cmd_err(cmd_err)
);

// File: tb/lvl_irq_ctrl_test.sv
module lvl_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        post_vld = 0, clr_vld = 0, clr_all = 0, ack = 0;
  logic [5:0]  post_level = 0, post_index = 0, clr_level = 0, clr_index = 0;
  logic [31:0] pc = 0, sw_req = 0;
  logic [4:0]  cur_ipl = 0;
  logic [31:0] lvl_status, int_sum;
  logic        irq_pending, irq_req, cmd_err;
  logic [4:0]  int_id;

  lvl_irq_ctrl uut (
    .clk(clk), .rst(rst), .post_vld(post_vld), .post_level(post_level),
    .post_index(post_index), .clr_vld(clr_vld), .clr_level(clr_level),
    .clr_index(clr_index), .clr_all(clr_all), .pc(pc), .sw_req(sw_req),
    .cur_ipl(cur_ipl), .ack(ack), .lvl_status(lvl_status), .irq_pending(irq_pending),
    .irq_req(irq_req), .int_id(int_id), .int_sum(int_sum), .cmd_err(cmd_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef enum int {O_STATUS, O_PEND, O_REQ, O_ID, O_SUM, O_ERR} sel_t;
  typedef struct {
    int          cyc;
    sel_t        sel;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int cyc_cnt = 0, checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk) cyc_cnt = cyc_cnt + 1;

  // Monitor: pops due items shortly after each falling edge and compares.
  initial forever begin
    @(negedge clk);
    #1;
    while (q.size() > 0 && q[0].cyc <= cyc_cnt) begin
      item_t it;
      logic [31:0] got;
      it = q.pop_front();
      case (it.sel)
        O_STATUS: got = lvl_status;
        O_PEND:   got = {31'd0, irq_pending};
        O_REQ:    got = {31'd0, irq_req};
        O_ID:     got = {27'd0, int_id};
        O_SUM:    got = int_sum;
        default:  got = {31'd0, cmd_err};
      endcase
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s %s: got %h expected %h", it.req, it.sel.name(), got, it.exp);
      end
    end
  end

  task automatic expect_now(string req, sel_t sel, logic [31:0] exp);
    q.push_back('{cyc_cnt, sel, exp, req});
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_post(int l, int i);
    post_vld = 1; post_level = 6'(l); post_index = 6'(i);
    @(negedge clk);
    post_vld = 0;
  endtask

  task automatic do_clr(int l, int i);
    clr_vld = 1; clr_level = 6'(l); clr_index = 6'(i);
    @(negedge clk);
    clr_vld = 0;
  endtask

  task automatic do_ack();
    ack = 1;
    @(negedge clk);
    ack = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 0;
    idle(1);
    // R11 reset values
    expect_now("R11", O_STATUS, 0); expect_now("R11", O_PEND, 0);
    expect_now("R11", O_REQ, 0);    expect_now("R11", O_ID, 0);
    expect_now("R11", O_SUM, 0);    expect_now("R11", O_ERR, 0);

    do_post(20, 3);
    expect_now("R1", O_STATUS, 32'h1 << 20);
    expect_now("R10", O_ERR, 0);
    idle(1);
    expect_now("R4", O_PEND, 1);
    expect_now("R8", O_REQ, 1);
    do_ack();
    expect_now("R8", O_ID, 20);
    expect_now("R6", O_SUM, 32'h1 << 20);
    expect_now("R8", O_REQ, 0);
    idle(1);
    expect_now("R8", O_REQ, 1);

    do_post(20, 7);
    do_clr(20, 3);
    expect_now("R2", O_STATUS, 32'h1 << 20);
    do_clr(20, 7);
    expect_now("R2", O_STATUS, 0);
    idle(1);
    expect_now("R4", O_PEND, 0);
    expect_now("R7", O_REQ, 0);

    pc = 32'h2;
    do_post(17, 0);
    expect_now("R1", O_STATUS, 32'h1 << 17);
    idle(1);
    expect_now("R4", O_PEND, 0);
    expect_now("R7", O_REQ, 0);
    pc = 32'h100;
    idle(1);
    expect_now("R4", O_PEND, 1);
    expect_now("R7", O_REQ, 1);

    sw_req = (32'h1 << 3) | (32'h1 << 5);
    idle(1);
    do_ack();
    expect_now("R6", O_ID, 17);
    expect_now("R5", O_SUM, (32'h1 << 17) | (32'h1 << 5) | (32'h1 << 3));

    clr_all = 1; idle(1); clr_all = 0;
    expect_now("R3", O_STATUS, 0);
    sw_req = sw_req | 32'h1 | (32'h1 << 20);
    idle(2);
    do_ack();
    expect_now("R5", O_ID, 5);
    expect_now("R5", O_SUM, (32'h1 << 5) | (32'h1 << 3));

    cur_ipl = 5;
    idle(2);
    expect_now("R7", O_REQ, 0);
    do_ack();
    expect_now("R9", O_ID, 5);
    expect_now("R9", O_SUM, (32'h1 << 5) | (32'h1 << 3));
    cur_ipl = 4;
    idle(1);
    expect_now("R7", O_REQ, 1);

    sw_req = 0; cur_ipl = 0;
    do_post(0, 1);
    expect_now("R10", O_ERR, 1);
    expect_now("R10", O_STATUS, 0);
    idle(1);
    expect_now("R10", O_ERR, 0);
    do_post(40, 0);
    expect_now("R10", O_ERR, 1);
    do_post(18, 40);
    expect_now("R10", O_ERR, 1);
    expect_now("R10", O_STATUS, 0);
    do_clr(50, 0);
    expect_now("R10", O_ERR, 1);

    clr_all = 1;
    do_post(25, 1);
    clr_all = 0;
    expect_now("R3", O_STATUS, 0);

    do_post(18, 2);
    do_post(30, 9);
    expect_now("R1", O_STATUS, (32'h1 << 18) | (32'h1 << 30));
    idle(1);
    do_ack();
    expect_now("R6", O_ID, 30);
    expect_now("R6", O_SUM, (32'h1 << 18) | (32'h1 << 30));

    cur_ipl = 30;
    idle(2);
    expect_now("R7", O_REQ, 0);
    cur_ipl = 29;
    idle(1);
    expect_now("R7", O_REQ, 1);

    idle(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule